// File: doc/BRIEF.md
# Channel-List Sequenced ADC Controller

This block sits between a small register bus and a 16-input, 12-bit sampling converter. Software loads a list of conversion entries. Each entry names an input channel, a gain step, a polarity and single-ended or differential wiring. Software then picks how conversions are triggered: by reading a start address, by an edge on an external trigger pin, or by an external edge that runs the whole list once. Each trigger takes the entry under the list pointer. The pointer then moves on and wraps to the first entry after the last one.

The converter is reached through a request/acknowledge handshake. The entry fields are presented while the request is held, and the converter returns a two's-complement code together with the acknowledge. Each returned code goes into a result FIFO with its top bit inverted, so the FIFO holds offset-binary data. Software reads results from one address and reads FIFO levels and the pending interrupt from the status address.

A half-full interrupt can be raised as the result FIFO fills. Any write to the interrupt-clear address removes it. Clearing either FIFO-enable bit empties the matching FIFO.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, status reads 0x0004 (result FIFO empty only), `conv_req` is low, `irq` is low and the result read returns 0.
- R2: Control register 1 bits [1:0] select the trigger mode: 0 off, 1 software, 2 scan, 3 external. In mode 0 no trigger of any kind starts a conversion. In mode 1 a read of address 0 starts exactly one conversion.
- R3: A list entry written to address 3 is 8 bits: [3:0] channel, [5:4] gain, [6] unipolar, [7] differential. These fields drive `conv_chan`, `conv_gain`, `conv_unipolar` and `conv_diff` during the conversion.
- R4: Successive conversions take list entries in write order, and the pointer wraps to the first entry after the last.
- R5: Each accepted sample is stored as `conv_data` with bit 11 inverted. Reads of address 3 return the samples in arrival order.
- R6: Status (read of address 2) carries these bits: bit 4 result FIFO full (16 entries), bit 3 at least half full (8 or more entries), bit 2 result FIFO empty, bit 1 channel list full (16 entries), bit 0 conversion in progress.
- R7: Control register 2 (address 1) bit 10 enables the result FIFO and bit 9 enables the channel list. While a bit is low, its FIFO is empty and list writes are ignored.
- R8: A result read on an empty FIFO returns the last value read and leaves the FIFO empty.
- R9: In mode 3 each edge of `ext_trig` starts one conversion. The edge is rising, or falling when control register 1 bit 3 is set.
- R10: In mode 2 one `ext_trig` edge converts every list entry once, in list order.
- R11: When control register 1 bit 8 is set and the result FIFO crosses to half full, status bit 8 becomes pending. `irq` is high while bit 8 is pending and control register 1 bit 15 is set. A write to address 2 clears the pending flag.
- R12: `conv_req` stays high until `conv_ack`. Triggers that arrive while a conversion is in progress are ignored.
- R13: A sample that arrives while the result FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe; data is valid the next cycle |
| bus_rdata | output | 16 | Registered read data |
| ext_trig | input | 1 | External trigger, synchronous to clk |
| conv_req | output | 1 | Conversion request, held until acknowledged |
| conv_chan | output | 4 | Channel of the current entry |
| conv_gain | output | 2 | Gain of the current entry |
| conv_unipolar | output | 1 | Unipolar range select |
| conv_diff | output | 1 | Differential input select |
| conv_ack | input | 1 | Converter done, one cycle |
| conv_data | input | 12 | Two's-complement conversion result |
| irq | output | 1 | Interrupt request |

## Verification
The converter's acknowledge can push a sample in the same cycle that a software read pops one from the result FIFO. The count must then stay level and both data words must be kept in order. The bench provokes this by priming the FIFO with one sample, then starting a conversion and issuing a result read after a random delay, so that some reads land on the acknowledge cycle. The popped word is judged against the oldest modelled sample, and the whole remaining stream is compared afterwards.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DATA_W = 12;
    localparam int REG_W  = 16;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_SW   = 2'd1,
        TRIG_SCAN = 2'd2,
        TRIG_EXT  = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic       diff;
        logic       unipolar;
        logic [1:0] gain;
        logic [3:0] chan;
    } list_entry_t;

    localparam logic [1:0] ADR_CTRL1_START = 2'd0;
    localparam logic [1:0] ADR_CTRL2       = 2'd1;
    localparam logic [1:0] ADR_STAT_ICLR   = 2'd2;
    localparam logic [1:0] ADR_LIST_RES    = 2'd3;

    localparam int C1_FALL   = 3;
    localparam int C1_HALFIE = 8;
    localparam int C1_GIE    = 15;
    localparam int C2_LISTEN = 9;
    localparam int C2_RESEN  = 10;

    localparam int ST_BUSY  = 0;
    localparam int ST_LFULL = 1;
    localparam int ST_EMPTY = 2;
    localparam int ST_HALF  = 3;
    localparam int ST_FULL  = 4;
    localparam int ST_HPEND = 8;

    function automatic logic [DATA_W-1:0] to_offset(input logic [DATA_W-1:0] v);
        return {~v[DATA_W-1], v[DATA_W-2:0]};
    endfunction

endpackage

// File: rtl/res_fifo.sv
module res_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // R13
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> (count == CNT_W'(DEPTH)));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/chan_list.sv
module chan_list
    import adc_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr,
    input  list_entry_t      wentry,
    input  logic             adv,
    output list_entry_t      cur,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    list_entry_t      mem [DEPTH];
    logic [PTR_W-1:0] idx;

    assign full = (count == CNT_W'(DEPTH));
    assign cur  = mem[idx];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            idx   <= '0;
        end else begin
            if (wr && !full) begin
                mem[count[PTR_W-1:0]] <= wentry;
                count <= count + 1'b1;
            end
            if (adv && count != '0)
                idx <= (CNT_W'(idx) + 1'b1 == count) ? '0 : idx + 1'b1;
        end
    end

    // R4
    ptr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> (CNT_W'(idx) < count));

endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  trig_mode_e       mode,
    input  logic             sw_start,
    input  logic             ext_edge,
    input  logic [CNT_W-1:0] list_count,
    input  logic             ack,
    output logic             busy,
    output logic             adv
);
    logic [CNT_W-1:0] left;
    logic             trig;

    always_comb begin
        unique case (mode)
            TRIG_SW:             trig = sw_start;
            TRIG_EXT, TRIG_SCAN: trig = ext_edge;
            default:             trig = 1'b0;
        endcase
    end

    assign adv = busy && ack && mode != TRIG_OFF && list_count != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
        end else if (mode == TRIG_OFF || list_count == '0) begin
            busy <= 1'b0;
            left <= '0;
        end else if (!busy) begin
            if (trig) begin
                busy <= 1'b1;
                left <= (mode == TRIG_SCAN) ? list_count : CNT_W'(1);
            end
        end else if (ack) begin
            left <= left - 1'b1;
            if (left <= CNT_W'(1))
                busy <= 1'b0;
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack && mode != TRIG_OFF && list_count != '0) |=> busy);

    // R2
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode == TRIG_OFF) |=> !busy);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int LIST_DEPTH = 16,
    parameter int RES_DEPTH  = 16,
    localparam int LCNT_W = $clog2(LIST_DEPTH + 1),
    localparam int RCNT_W = $clog2(RES_DEPTH + 1),
    localparam int HALF   = RES_DEPTH / 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    input  logic        bus_rd,
    output logic [15:0] bus_rdata,
    input  logic        ext_trig,
    output logic        conv_req,
    output logic [3:0]  conv_chan,
    output logic [1:0]  conv_gain,
    output logic        conv_unipolar,
    output logic        conv_diff,
    input  logic        conv_ack,
    input  logic [11:0] conv_data,
    output logic        irq
);
    logic [REG_W-1:0]  ctrl1, ctrl2;
    logic              ext_q, half_q, hpend;
    logic [DATA_W-1:0] last_res;

    trig_mode_e        mode;
    list_entry_t       cur;
    logic [LCNT_W-1:0] lcount;
    logic              lfull, busy, adv;
    logic [DATA_W-1:0] rdout;
    logic [RCNT_W-1:0] rcount;
    logic              rfull, rempty, rhalf;
    logic              ext_edge, sw_start, list_wr, res_pop, iclr_wr, hset;
    logic [REG_W-1:0]  status;

    assign mode     = trig_mode_e'(ctrl1[1:0]);
    assign ext_edge = ctrl1[C1_FALL] ? (ext_q && !ext_trig) : (!ext_q && ext_trig);
    assign sw_start = bus_rd && bus_addr == ADR_CTRL1_START;
    assign list_wr  = bus_wr && bus_addr == ADR_LIST_RES;
    assign res_pop  = bus_rd && bus_addr == ADR_LIST_RES;
    assign iclr_wr  = bus_wr && bus_addr == ADR_STAT_ICLR;
    assign rhalf    = (rcount >= RCNT_W'(HALF));
    assign hset     = rhalf && !half_q && ctrl1[C1_HALFIE];

    chan_list #(.DEPTH(LIST_DEPTH)) u_list (
        .clk    (clk),
        .rst    (rst),
        .clr    (!ctrl2[C2_LISTEN]),
        .wr     (list_wr),
        .wentry (list_entry_t'(bus_wdata[7:0])),
        .adv    (adv),
        .cur    (cur),
        .count  (lcount),
        .full   (lfull)
    );

    conv_seq #(.CNT_W(LCNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .sw_start   (sw_start),
        .ext_edge   (ext_edge),
        .list_count (lcount),
        .ack        (conv_ack),
        .busy       (busy),
        .adv        (adv)
    );

    res_fifo #(.W(DATA_W), .DEPTH(RES_DEPTH)) u_res (
        .clk   (clk),
        .rst   (rst),
        .clr   (!ctrl2[C2_RESEN]),
        .push  (adv),
        .din   (to_offset(conv_data)),
        .pop   (res_pop),
        .dout  (rdout),
        .count (rcount),
        .full  (rfull),
        .empty (rempty)
    );

    assign conv_req      = busy;
    assign conv_chan     = cur.chan;
    assign conv_gain     = cur.gain;
    assign conv_unipolar = cur.unipolar;
    assign conv_diff     = cur.diff;
    assign irq           = hpend && ctrl1[C1_GIE];

    always_comb begin
        status           = '0;
        status[ST_BUSY]  = busy;
        status[ST_LFULL] = lfull;
        status[ST_EMPTY] = rempty;
        status[ST_HALF]  = rhalf;
        status[ST_FULL]  = rfull;
        status[ST_HPEND] = hpend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl1     <= '0;
            ctrl2     <= '0;
            ext_q     <= 1'b0;
            half_q    <= 1'b0;
            hpend     <= 1'b0;
            last_res  <= '0;
            bus_rdata <= '0;
        end else begin
            ext_q  <= ext_trig;
            half_q <= rhalf;
            hpend  <= hset || (hpend && !iclr_wr);
            if (bus_wr && bus_addr == ADR_CTRL1_START) ctrl1 <= bus_wdata;
            if (bus_wr && bus_addr == ADR_CTRL2)       ctrl2 <= bus_wdata;
            if (bus_rd) begin
                unique case (bus_addr)
                    ADR_STAT_ICLR: bus_rdata <= status;
                    ADR_LIST_RES: begin
                        bus_rdata <= rempty ? REG_W'(last_res) : REG_W'(rdout);
                        if (!rempty) last_res <= rdout;
                    end
                    default:       bus_rdata <= '0;
                endcase
            end
        end
    end

    // R3
    entry_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_ack && ctrl2[C2_LISTEN])
        |=> $stable({conv_diff, conv_unipolar, conv_gain, conv_chan}));

    // R11
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (iclr_wr && !hset) |=> !hpend);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl1[C1_GIE] && !(bus_wr && bus_addr == ADR_CTRL1_START)) |=> !irq);

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic        conv_req;
    logic [3:0]  conv_chan;
    logic [1:0]  conv_gain;
    logic        conv_unipolar, conv_diff;
    logic        conv_ack = 1'b0;
    logic [11:0] conv_data = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0, n_conv = 0;
    logic [7:0]  lst [16];
    int          lcnt = 0, lidx = 0;
    bit          list_en_m = 0, res_en_m = 0;
    logic [7:0]  seen_q [$];
    logic [11:0] exp_q [$];
    logic [11:0] last_m = '0;
    bit          done = 0;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .ext_trig(ext_trig), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_gain(conv_gain), .conv_unipolar(conv_unipolar),
        .conv_diff(conv_diff), .conv_ack(conv_ack), .conv_data(conv_data),
        .irq(irq)
    );

    always #2.5 clk = ~clk;

    // converter model: acknowledge on the third cycle of a request
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (conv_ack) begin
                conv_ack = 1'b0;
                lat = 0;
            end else if (conv_req && !rst) begin
                lat++;
                if (lat == 3) begin
                    logic [11:0] d;
                    d = 12'($urandom);
                    conv_data = d;
                    conv_ack = 1'b1;
                    seen_q.push_back({conv_diff, conv_unipolar, conv_gain, conv_chan});
                    n_conv++;
                    if (res_en_m && exp_q.size() < 16)
                        exp_q.push_back({~d[11], d[10:0]});
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl2(input bit len, input bit ren);
        wr(2'd1, 16'((ren << 10) | (len << 9)));
        list_en_m = len; res_en_m = ren;
        if (!len) begin lcnt = 0; lidx = 0; end
        if (!ren) exp_q.delete();
    endtask

    task automatic add_entry(input logic [7:0] e);
        wr(2'd3, {8'h0, e});
        if (list_en_m && lcnt < 16) begin lst[lcnt] = e; lcnt++; end
    endtask

    task automatic check_seen(input string req);
        while (seen_q.size() > 0) begin
            logic [7:0] s;
            s = seen_q.pop_front();
            chk(s == lst[lidx], req, s, lst[lidx]);
            lidx = (lidx + 1) % lcnt;
        end
    endtask

    task automatic read_res(input string req);
        logic [15:0] v;
        logic [11:0] e;
        rd(2'd3, v);
        if (exp_q.size() > 0) begin e = exp_q.pop_front(); last_m = e; end
        else e = last_m;
        chk(v == {4'h0, e}, req, v, e);
    endtask

    task automatic sw_conv();
        logic [15:0] v;
        rd(2'd0, v);
        settle(8);
    endtask

    task automatic new_list(input int n);
        set_ctrl2(0, res_en_m);
        set_ctrl2(1, res_en_m);
        for (int k = 0; k < n; k++) add_entry(8'($urandom));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int c0;
        process::self().srandom(32'd1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(conv_req == 0, "R1 conv_req", conv_req, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        rd(2'd2, v);
        chk(v == 16'h0004, "R1 status", v, 16'h0004);
        rd(2'd3, v);
        chk(v == 16'h0000, "R1 result", v, 0);

        // R2 mode off ignores start reads and edges
        set_ctrl2(1, 1);
        add_entry(8'h35); add_entry(8'hC2); add_entry(8'h4F);
        wr(2'd0, 16'h0000);
        c0 = n_conv;
        rd(2'd0, v); ext_trig = 1; settle(2); ext_trig = 0; settle(8);
        chk(n_conv == c0, "R2 off mode", n_conv - c0, 0);

        // R2 R3 R4 R5 software trigger cycles through the list
        wr(2'd0, 16'h0001);
        for (int k = 0; k < 7; k++) begin
            c0 = n_conv;
            sw_conv();
            chk(n_conv == c0 + 1, "R2 one conversion per start", n_conv - c0, 1);
        end
        check_seen("R3 R4 entry fields and wrap");
        for (int k = 0; k < 7; k++) read_res("R5 offset-binary result");

        // R8 empty read returns last value
        read_res("R8 empty read");
        rd(2'd2, v);
        chk(v[2] == 1, "R8 still empty", v, 16'h0004);

        // R12 trigger while busy ignored
        c0 = n_conv;
        rd(2'd0, v);
        rd(2'd0, v);
        settle(10);
        chk(n_conv == c0 + 1, "R12 start while busy", n_conv - c0, 1);
        check_seen("R12 entry");
        read_res("R12 result");

        // R6 R11 R13 fill result FIFO
        wr(2'd0, 16'h8101);
        for (int k = 0; k < 8; k++) sw_conv();
        rd(2'd2, v);
        chk(v == 16'h0108, "R6 R11 half status", v, 16'h0108);
        chk(irq == 1, "R11 irq", irq, 1);
        for (int k = 0; k < 9; k++) sw_conv();
        rd(2'd2, v);
        chk(v == 16'h0118, "R6 full status", v, 16'h0118);
        check_seen("R13 entries");
        for (int k = 0; k < 16; k++) read_res("R13 drop when full");
        rd(2'd2, v);
        chk(v == 16'h0104, "R11 pending kept", v, 16'h0104);
        wr(2'd2, 16'h0000);
        rd(2'd2, v);
        chk(v == 16'h0004, "R11 cleared", v, 16'h0004);
        chk(irq == 0, "R11 irq low", irq, 0);
        wr(2'd0, 16'h0001);

        // R7 disabled list ignores writes, R6 list full
        set_ctrl2(0, 1);
        add_entry(8'h11);
        set_ctrl2(1, 1);
        c0 = n_conv;
        sw_conv();
        chk(n_conv == c0, "R7 list write ignored", n_conv - c0, 0);
        for (int k = 0; k < 16; k++) add_entry(8'($urandom));
        rd(2'd2, v);
        chk(v[1] == 1, "R6 list full", v, 16'h0006);
        sw_conv(); sw_conv();
        check_seen("R7 entries");
        set_ctrl2(1, 0);
        set_ctrl2(1, 1);
        rd(2'd2, v);
        chk(v == 16'h0006, "R7 result cleared", v, 16'h0006);

        // R9 external edges
        new_list(3);
        wr(2'd0, 16'h0003);
        c0 = n_conv;
        ext_trig = 1; settle(10);
        chk(n_conv == c0 + 1, "R9 rising edge", n_conv - c0, 1);
        ext_trig = 0; settle(10);
        chk(n_conv == c0 + 1, "R9 fall ignored", n_conv - c0, 1);
        wr(2'd0, 16'h000B);
        ext_trig = 1; settle(10);
        chk(n_conv == c0 + 1, "R9 rise ignored", n_conv - c0, 1);
        ext_trig = 0; settle(10);
        chk(n_conv == c0 + 2, "R9 falling edge", n_conv - c0, 2);
        check_seen("R9 entries");
        read_res("R9 result"); read_res("R9 result");

        // R10 scan converts the whole list once
        new_list(4);
        wr(2'd0, 16'h0002);
        c0 = n_conv;
        ext_trig = 1; settle(40); ext_trig = 0; settle(4);
        chk(n_conv == c0 + 4, "R10 scan count", n_conv - c0, 4);
        check_seen("R10 scan order");
        for (int k = 0; k < 4; k++) read_res("R10 scan result");

        // random: result reads colliding with pushes
        new_list(5);
        wr(2'd0, 16'h0001);
        sw_conv();
        for (int k = 0; k < 40; k++) begin
            rd(2'd0, v);
            settle(int'($urandom_range(0, 4)));
            read_res("R5 read during push");
            settle(8);
        end
        check_seen("R4 random entries");
        read_res("R5 tail");
        rd(2'd2, v);
        chk(v[2] == 1, "R6 empty at end", v, 16'h0004);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule